// File: doc/BRIEF.md
# Dual Halfword Signed Multiply-Accumulate Unit

This execute-stage datapath serves four related operations that each multiply two pairs of signed 16-bit halves taken from two 32-bit source operands. The low half of the first source is multiplied by the low half of the second, and the high half by the high half. The two products are then summed or differenced. The register file can supply a third 32-bit value to be added to that intermediate. The final 32-bit result is written to a destination register. A sticky saturation flag records signed overflow on the additions that the operation defines.

The unit decodes the register indices, the swap bit and the add/subtract selector directly from the 32-bit instruction word. The register file reads the index outputs and supplies the operand values in the same cycle. A condition field of 0xE always executes. Any other condition code relies on an external pass signal. The computation is combinational and is captured in one output register stage, so a result appears one clock after the operation is presented.

Top module: `dual_mac16`

## Requirements
- R1: While reset is asserted and just after it, `out_valid`, `wr_en` and `q_flag` are 0.
- R2: The index outputs decode the instruction combinationally: `idx_n` = bits 3:0, `idx_m` = bits 11:8, `idx_a` = bits 15:12. A registered `wr_idx` carries bits 19:16 of the accepted instruction.
- R3: An operation executes when instruction bits 31:28 equal 0xE or when `cond_pass` is 1. A non-executing operation produces `wr_en` = 0 and leaves `q_flag` unchanged.
- R4: When instruction bit 5 is 1, the upper and lower 16-bit halves of `src_m` are exchanged before multiplication.
- R5: Halves are two's-complement. When instruction bit 6 is 0, the intermediate is lo(n)*lo(m) + hi(n)*hi(m), wrapped to 32 bits.
- R6: When instruction bit 6 is 1, the intermediate is lo(n)*lo(m) − hi(n)*hi(m).
- R7: When `idx_a` is not 15, `acc_in` is added to the intermediate modulo 2^32. When `idx_a` is 15, the intermediate is the result.
- R8: In the add form, `q_flag` is set if the two products' signed 32-bit sum overflows. This includes the case where all four halves are −32768.
- R9: In either form, `q_flag` is set if adding `acc_in` to the intermediate overflows, where overflow means equal addend signs and a differing sum sign.
- R10: In the subtract form, the product difference alone never sets `q_flag`.
- R11: `q_flag` is sticky. Only reset clears it, and the destination still receives the wrapped result.
- R12: `out_valid`, `wr_en`, `wr_idx` and `result` are registered. They reflect the operation accepted with `in_valid` on the previous rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An operation is presented this cycle |
| instr | input | 32 | Instruction word |
| cond_pass | input | 1 | External condition evaluation result |
| src_n | input | 32 | First multiplicand operand |
| src_m | input | 32 | Second multiplicand operand |
| acc_in | input | 32 | Accumulator operand |
| idx_n | output | 4 | Register index of the first multiplicand |
| idx_m | output | 4 | Register index of the second multiplicand |
| idx_a | output | 4 | Register index of the accumulator |
| out_valid | output | 1 | Registered result slot is occupied |
| wr_en | output | 1 | Destination register write enable |
| wr_idx | output | 4 | Destination register index |
| result | output | 32 | Wrapped 32-bit result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
In the add form, the product-pair overflow and the accumulate overflow can occur in the same operation. The bench provokes this by setting all four halves to −32768, which gives a product sum of 2^31, and then adding 0x80000000, which wraps the total to zero. The result must be 0 and the flag must be 1. Each detector is also triggered alone after a fresh reset, so that a missing source is not hidden by the sticky flag.

// File: rtl/dual_mac16.sv
module dual_mac16 #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter logic [3:0] ALWAYS_COND = 4'hE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [31:0]       instr,
  input  logic              cond_pass,
  input  logic [DATA_W-1:0] src_n,
  input  logic [DATA_W-1:0] src_m,
  input  logic [DATA_W-1:0] acc_in,
  output logic [IDX_W-1:0]  idx_n,
  output logic [IDX_W-1:0]  idx_m,
  output logic [IDX_W-1:0]  idx_a,
  output logic              out_valid,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] result,
  output logic              q_flag
);
  localparam int H   = DATA_W / 2;
  localparam int MSB = DATA_W - 1;
  localparam logic [IDX_W-1:0] NO_ACC = {IDX_W{1'b1}};

  logic              executes, swap, sub_form, use_acc;
  logic [DATA_W-1:0] m_eff, p_lo, p_hi, pair_sum, pair_diff, mid, acc_sum, total;
  logic              ov_pair, ov_acc;

  assign idx_n    = instr[3:0];
  assign idx_m    = instr[11:8];
  assign idx_a    = instr[15:12];
  assign swap     = instr[5];
  assign sub_form = instr[6];
  assign executes = (instr[31:28] == ALWAYS_COND) || cond_pass;
  assign use_acc  = (idx_a != NO_ACC);

  assign m_eff = swap ? {src_m[H-1:0], src_m[DATA_W-1:H]} : src_m;

  assign p_lo = $signed({{H{src_n[H-1]}}, src_n[H-1:0]}) *
                $signed({{H{m_eff[H-1]}}, m_eff[H-1:0]});
  assign p_hi = $signed({{H{src_n[MSB]}}, src_n[DATA_W-1:H]}) *
                $signed({{H{m_eff[MSB]}}, m_eff[DATA_W-1:H]});

  assign pair_sum  = p_lo + p_hi;
  assign pair_diff = p_lo - p_hi;
  assign mid       = sub_form ? pair_diff : pair_sum;
  assign acc_sum   = mid + acc_in;
  assign total     = use_acc ? acc_sum : mid;

  assign ov_pair = !sub_form && (p_lo[MSB] == p_hi[MSB]) && (pair_sum[MSB] != p_lo[MSB]);
  assign ov_acc  = use_acc && (mid[MSB] == acc_in[MSB]) && (acc_sum[MSB] != mid[MSB]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      wr_idx    <= '0;
      result    <= '0;
      q_flag    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && executes;
      if (in_valid) begin
        wr_idx <= instr[19:16];
        result <= total;
      end
      if (in_valid && executes && (ov_pair || ov_acc))
        q_flag <= 1'b1;
    end
  end

  assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_wr_needs_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> out_valid);
  assert_skip_keeps_q_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !executes) |=> $stable(q_flag));
  assert_q_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    q_flag |=> q_flag);
  assert_dest_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (wr_idx == $past(instr[19:16])));
  assert_diff_no_q_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && sub_form && !use_acc) |=> $stable(q_flag));
endmodule

// File: tb/dual_mac16_tb_top.sv
`timescale 1ns/100ps
module dual_mac16_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, cond_pass = 1'b0;
  logic [31:0] instr = '0, src_n = '0, src_m = '0, acc_in = '0;
  logic [3:0] idx_n, idx_m, idx_a, wr_idx;
  logic out_valid, wr_en, q_flag;
  logic [31:0] result;

  always #2.5 clk = ~clk;

  dual_mac16 dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
    .cond_pass(cond_pass), .src_n(src_n), .src_m(src_m), .acc_in(acc_in),
    .idx_n(idx_n), .idx_m(idx_m), .idx_a(idx_a), .out_valid(out_valid),
    .wr_en(wr_en), .wr_idx(wr_idx), .result(result), .q_flag(q_flag));

  typedef struct {
    bit        wr;
    bit [3:0]  idx;
    bit [31:0] res;
    bit        q;
    string     tag;
  } exp_t;

  exp_t exp_q[$];
  int   tests = 0, fails = 0;
  bit   q_model = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] mk(input bit [3:0] cnd, input bit [3:0] rd, input bit [3:0] ra,
                                   input bit [3:0] rm, input bit [3:0] rn, input bit sub, input bit sw);
    return {cnd, 8'h70, rd, ra, rm, 1'b0, sub, sw, 1'b1, rn};
  endfunction

  task automatic op(input bit [31:0] ins, input bit cp, input bit [31:0] a, input bit [31:0] b,
                    input bit [31:0] acc, input string tag);
    exp_t e;
    bit [31:0] bs, mid32;
    longint p1, p2, mid, tot;
    bit ov, ex;
    @(negedge clk);
    instr = ins; cond_pass = cp; src_n = a; src_m = b; acc_in = acc; in_valid = 1'b1;
    bs  = ins[5] ? {b[15:0], b[31:16]} : b;
    p1  = longint'($signed(a[15:0])) * longint'($signed(bs[15:0]));
    p2  = longint'($signed(a[31:16])) * longint'($signed(bs[31:16]));
    ov  = 1'b0;
    mid = ins[6] ? p1 - p2 : p1 + p2;
    if (!ins[6] && (mid > 64'sd2147483647 || mid < -64'sd2147483648)) ov = 1'b1;
    mid32 = mid[31:0];
    if (ins[15:12] != 4'hF) begin
      tot = longint'($signed(mid32)) + longint'($signed(acc));
      if (tot > 64'sd2147483647 || tot < -64'sd2147483648) ov = 1'b1;
      e.res = tot[31:0];
    end else e.res = mid32;
    ex = (ins[31:28] == 4'hE) || cp;
    q_model = q_model | (ex & ov);
    e.wr = ex; e.idx = ins[19:16]; e.q = q_model; e.tag = tag;
    exp_q.push_back(e);
    #1;
    check(idx_n == ins[3:0] && idx_m == ins[11:8] && idx_a == ins[15:12],
          {"R2 index decode ", tag}, {20'h0, idx_a, idx_m, idx_n}, {20'h0, ins[15:8], ins[3:0]});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic do_reset;
    idle(2);
    rst_n = 1'b0;
    q_model = 1'b0;
    idle(2);
    check(out_valid == 1'b0 && wr_en == 1'b0 && q_flag == 1'b0, "R1 reset state",
          {29'h0, out_valid, wr_en, q_flag}, 32'h0);
    rst_n = 1'b1;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected result", 32'h1, 32'h0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(wr_en == e.wr, {"R3 write enable ", e.tag}, {31'h0, wr_en}, {31'h0, e.wr});
        if (e.wr) begin
          check(wr_idx == e.idx, {"R2 dest index ", e.tag}, {28'h0, wr_idx}, {28'h0, e.idx});
          check(result == e.res, {"R5 R6 R7 result ", e.tag}, result, e.res);
        end
        check(q_flag == e.q, {"R8 R9 R10 R11 q flag ", e.tag}, {31'h0, q_flag}, {31'h0, e.q});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h1, 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R5 plain add, R4 swap, negative halves
    op(mk(4'hE, 4'd2, 4'hF, 4'd1, 4'd0, 0, 0), 0, 32'h0003_0002, 32'h0005_0004, 0, "R5 add 23");
    op(mk(4'hE, 4'd3, 4'hF, 4'd1, 4'd0, 0, 1), 0, 32'h0003_0002, 32'h0005_0004, 0, "R4 swap 22");
    op(mk(4'hE, 4'd4, 4'hF, 4'd1, 4'd0, 0, 0), 0, 32'hFFFF_FFFE, 32'h0003_0004, 0, "R5 negative");
    // R6 subtract, R7 accumulate and wrap
    op(mk(4'hE, 4'd5, 4'hF, 4'd1, 4'd0, 1, 0), 0, 32'h0003_0002, 32'h0005_0004, 0, "R6 sub");
    op(mk(4'hE, 4'd6, 4'd3, 4'd1, 4'd0, 0, 0), 0, 32'h0003_0002, 32'h0005_0004, 100, "R7 acc");
    op(mk(4'hE, 4'd7, 4'd3, 4'd1, 4'd0, 0, 0), 0, 32'h0003_0002, 32'h0005_0004, 32'hFFFF_FFFF, "R7 wrap");
    op(mk(4'hE, 4'd8, 4'd9, 4'd1, 4'd0, 1, 1), 0, 32'h1234_8001, 32'h7FFF_0010, 32'h0000_0777, "R6 R7 sub acc swap");
    // R3 condition gating, with overflowing operand so Q must stay unchanged
    op(mk(4'h0, 4'd9, 4'hF, 4'd1, 4'd0, 0, 0), 0, 32'h8000_8000, 32'h8000_8000, 0, "R3 cond fail");
    op(mk(4'h1, 4'd10, 4'hF, 4'd1, 4'd0, 0, 0), 1, 32'h0003_0002, 32'h0005_0004, 0, "R3 cond pass");
    op(mk(4'hE, 4'd11, 4'hF, 4'd1, 4'd0, 0, 0), 0, 32'h0001_0001, 32'h0001_0001, 0, "R3 always");
    idle(2);
    check(q_flag == 1'b0, "R3 skipped op leaves q clear", {31'h0, q_flag}, 32'h0);
    // R8 product-pair overflow alone, then R11 stickiness
    op(mk(4'hE, 4'd1, 4'hF, 4'd3, 4'd2, 0, 0), 0, 32'h8000_8000, 32'h8000_8000, 0, "R8 pair overflow");
    op(mk(4'hE, 4'd1, 4'hF, 4'd3, 4'd2, 0, 0), 0, 32'h0001_0001, 32'h0001_0001, 0, "R11 sticky");
    do_reset();
    // R8 and R9 in the same operation
    op(mk(4'hE, 4'd1, 4'd4, 4'd3, 4'd2, 0, 0), 0, 32'h8000_8000, 32'h8000_8000, 32'h8000_0000, "R8 R9 both");
    do_reset();
    // R9 accumulate overflow alone, add form
    op(mk(4'hE, 4'd1, 4'd4, 4'd3, 4'd2, 0, 0), 0, 32'h0000_7FFF, 32'h0000_7FFF, 32'h7FFF_FFFF, "R9 acc add form");
    do_reset();
    // R10 large difference without accumulate must not set Q
    op(mk(4'hE, 4'd1, 4'hF, 4'd3, 4'd2, 1, 0), 0, 32'h8000_8000, 32'h7FFF_8000, 0, "R10 diff only");
    idle(2);
    check(q_flag == 1'b0, "R10 difference leaves q clear", {31'h0, q_flag}, 32'h0);
    // R9 accumulate overflow in subtract form
    op(mk(4'hE, 4'd1, 4'd4, 4'd3, 4'd2, 1, 0), 0, 32'h8000_8000, 32'h7FFF_8000, 32'h0001_0000, "R9 acc sub form");
    idle(3);
    check(exp_q.size() == 0, "R12 all results seen", exp_q.size(), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule